// File: doc/BRIEF.md
# Break Glitch Filter

This block removes short noise spikes from two fault ("break") channels before they reach the shutdown controller of a PWM stage. Each channel takes one break level from an external pin and one from an internal comparator. Each level first has its own polarity applied, and the two results are ORed. The pin level passes through a two-flop synchronizer first. The comparator level is taken as already synchronous.

The combined level is sampled on ticks of a prescaled clock. A break is declared only after a run of consecutive asserted samples. A single 4-bit code per channel selects both the tick divider and the run length. This lets one field cover rejection windows from two cycles up to a few hundred cycles. Code zero turns the filter off and passes the polarity-corrected level straight through.

Top module: `break_glitch_filter`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, both filtered outputs are low whenever the channel code is non-zero. All sample counters restart from zero.
- R2: With code 0 the output equals the polarity-corrected break level. A comparator change reaches the output without any clock edge.
- R3: Polarity bit 1 means a source is asserted when high. Polarity bit 0 means it is asserted when low. Each source of a channel is corrected on its own, and the two are ORed.
- R4: Codes map to (tick divider D, sample count N) as follows: 1→(1,2), 2→(1,4), 3→(1,8), 4→(2,6), 5→(2,8), 6→(4,6), 7→(4,8), 8→(8,6), 9→(8,8), 10→(16,6), 11→(16,8), 12→(32,6), 13 to 15→(32,8). Ticks come from a free-running 5-bit prescaler that is cleared by reset.
- R5: The output rises at the tick on which the N-th consecutive asserted sample is taken. A pulse of at most (N-1)·D cycles never raises it. A pulse of N·D cycles or more always raises it.
- R6: A deasserted sample clears the run count, so two shorter runs separated by a gap do not add up.
- R7: A filtered output falls on the first tick that samples a deasserted level. With D=1 and the comparator source, it is low one clock edge after the level drops.
- R8: A pin level crosses a two-flop synchronizer before it is used. With code 0 the output follows the pin after two edges. With code 1 it follows the pin after four edges.
- R9: The two channels are independent. Stimulus on one channel never moves the other channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brk_pin_a | input | 1 | Channel A external break level (asynchronous) |
| brk_cmp_a | input | 1 | Channel A comparator break level |
| pol_a | input | 1 | Channel A polarity: 1 active high, 0 active low |
| flt_code_a | input | 4 | Channel A filter code |
| brk_pin_b | input | 1 | Channel B external break level (asynchronous) |
| brk_cmp_b | input | 1 | Channel B comparator break level |
| pol_b | input | 1 | Channel B polarity |
| flt_code_b | input | 4 | Channel B filter code |
| brk_a | output | 1 | Channel A filtered break |
| brk_b | output | 1 | Channel B filtered break |

## Verification
A run counter that is stuck or misses a clear shows up as a filtered break that fires on a pulse one sample too short. It can also show up as one that never fires on a pulse that is long enough. Either is visible within N·D cycles of the pulse start. A wrong divider decode shifts the accept and reject boundary by whole multiples of D, so each code is probed just below and just at its window. A filtered flag that fails to clear stays high more than D cycles after the level drops, and the bench checks that after every pulse.

// File: rtl/break_glitch_filter.sv
module break_glitch_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       brk_pin_a,
  input  logic       brk_cmp_a,
  input  logic       pol_a,
  input  logic [3:0] flt_code_a,
  input  logic       brk_pin_b,
  input  logic       brk_cmp_b,
  input  logic       pol_b,
  input  logic [3:0] flt_code_b,
  output logic       brk_a,
  output logic       brk_b
);

  logic [1:0][SYNC_STAGES-1:0] sync_q;
  logic [1:0]                  pin, cmp, pol, hit, tick, flt;
  logic [1:0][3:0]             code, need, cnt;
  logic [1:0][4:0]             mask;
  logic [4:0]                  psc;

  function automatic logic [8:0] decode(input logic [3:0] c);
    case (c)
      4'd1:    decode = {5'd0,  4'd2};
      4'd2:    decode = {5'd0,  4'd4};
      4'd3:    decode = {5'd0,  4'd8};
      4'd4:    decode = {5'd1,  4'd6};
      4'd5:    decode = {5'd1,  4'd8};
      4'd6:    decode = {5'd3,  4'd6};
      4'd7:    decode = {5'd3,  4'd8};
      4'd8:    decode = {5'd7,  4'd6};
      4'd9:    decode = {5'd7,  4'd8};
      4'd10:   decode = {5'd15, 4'd6};
      4'd11:   decode = {5'd15, 4'd8};
      4'd12:   decode = {5'd31, 4'd6};
      4'd0:    decode = {5'd0,  4'd1};
      default: decode = {5'd31, 4'd8};
    endcase
  endfunction

  assign pin  = {brk_pin_b, brk_pin_a};
  assign cmp  = {brk_cmp_b, brk_cmp_a};
  assign pol  = {pol_b, pol_a};
  assign code = {flt_code_b, flt_code_a};

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      {mask[i], need[i]} = decode(code[i]);
      hit[i]  = (sync_q[i][SYNC_STAGES-1] ~^ pol[i]) | (cmp[i] ~^ pol[i]);
      tick[i] = (psc & mask[i]) == mask[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      psc    <= '0;
      cnt    <= '0;
      flt    <= '0;
    end else begin
      psc <= psc + 5'd1;
      for (int i = 0; i < 2; i++) begin
        sync_q[i] <= {sync_q[i][SYNC_STAGES-2:0], pin[i]};
        if (tick[i]) begin
          if (!hit[i]) begin
            cnt[i] <= '0;
            flt[i] <= 1'b0;
          end else begin
            if (cnt[i] != need[i]) cnt[i] <= cnt[i] + 4'd1;
            if (cnt[i] + 4'd1 >= need[i]) flt[i] <= 1'b1;
          end
        end
      end
    end
  end

  assign brk_a = (flt_code_a == 4'd0) ? hit[0] : flt[0];
  assign brk_b = (flt_code_b == 4'd0) ? hit[1] : flt[1];

endmodule

// File: rtl/break_glitch_filter_chk.sv
module break_glitch_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] code_a,
  input logic       hit_a,
  input logic       brk_a,
  input logic [3:0] code_b,
  input logic       brk_b
);

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rst_n) && code_a != 4'd0 && code_b != 4'd0) |-> (!brk_a && !brk_b));

  p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (code_a == 4'd0 && hit_a) |-> brk_a);

  p_rise_needs_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(brk_a) && code_a != 4'd0 && $stable(code_a)) |-> $past(hit_a));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_a && code_a != 4'd0 && $stable(code_a)) |-> ($past(brk_a) || $past(hit_a)));

  p_fall_on_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(brk_a) && code_a != 4'd0 && $stable(code_a)) |-> !$past(hit_a));

endmodule

bind break_glitch_filter break_glitch_filter_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .code_a (flt_code_a),
  .hit_a  (hit[0]),
  .brk_a  (brk_a),
  .code_b (flt_code_b),
  .brk_b  (brk_b)
);

// File: tb/break_glitch_filter_tb.sv
`timescale 1ns/1ps
module break_glitch_filter_tb;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pin_a = 0, cmp_a = 0, pol_a = 1, pin_b = 0, cmp_b = 0, pol_b = 1;
  logic [3:0] code_a = 4'd1, code_b = 4'd1;
  logic brk_a, brk_b;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  break_glitch_filter u_dut (
    .clk(clk), .rst_n(rst_n),
    .brk_pin_a(pin_a), .brk_cmp_a(cmp_a), .pol_a(pol_a), .flt_code_a(code_a),
    .brk_pin_b(pin_b), .brk_cmp_b(cmp_b), .pol_b(pol_b), .flt_code_b(code_b),
    .brk_a(brk_a), .brk_b(brk_b)
  );

  // {ch, use_pin, code[3:0], len[8:0], expect}
  localparam logic [15:0] VEC [16] = '{
    {1'b0, 1'b0, 4'd1,  9'd1,   1'b0},
    {1'b0, 1'b0, 4'd1,  9'd2,   1'b1},
    {1'b0, 1'b0, 4'd3,  9'd7,   1'b0},
    {1'b0, 1'b0, 4'd3,  9'd8,   1'b1},
    {1'b0, 1'b0, 4'd8,  9'd40,  1'b0},
    {1'b0, 1'b0, 4'd8,  9'd48,  1'b1},
    {1'b0, 1'b1, 4'd8,  9'd40,  1'b0},
    {1'b0, 1'b1, 4'd8,  9'd48,  1'b1},
    {1'b1, 1'b0, 4'd5,  9'd14,  1'b0},
    {1'b1, 1'b0, 4'd5,  9'd16,  1'b1},
    {1'b1, 1'b1, 4'd11, 9'd112, 1'b0},
    {1'b1, 1'b1, 4'd11, 9'd128, 1'b1},
    {1'b1, 1'b0, 4'd15, 9'd224, 1'b0},
    {1'b1, 1'b0, 4'd15, 9'd256, 1'b1},
    {1'b0, 1'b0, 4'd12, 9'd160, 1'b0},
    {1'b0, 1'b0, 4'd12, 9'd192, 1'b1}
  };

  function automatic int div_of(input logic [3:0] c);
    if (c <= 4'd3) return 1;
    if (c <= 4'd5) return 2;
    if (c <= 4'd7) return 4;
    if (c <= 4'd9) return 8;
    if (c <= 4'd11) return 16;
    return 32;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic set_src(input logic ch, input logic use_pin, input logic v);
    if (!ch) begin if (use_pin) pin_a = v; else cmp_a = v; end
    else     begin if (use_pin) pin_b = v; else cmp_b = v; end
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic seen, outv;
    int d;
    #1;
    check("R1 reset brk_a", brk_a, 1'b0);
    check("R1 reset brk_b", brk_b, 1'b0);
    cmp_a = 1;
    #12;
    check("R1 reset holds brk_a low with asserted level", brk_a, 1'b0);
    @(negedge clk);
    rst_n = 1;
    cmp_a = 0;
    cyc(4);

    // table walk: R4 and R5 window edges, R7 drop after pulse, R9 side channel
    foreach (VEC[v]) begin
      logic ch, up, ex;
      logic [3:0] cd;
      int len;
      {ch, up, cd} = VEC[v][15:10];
      len = int'(VEC[v][9:1]);
      ex  = VEC[v][0];
      d   = div_of(cd);
      if (!ch) code_a = cd; else code_b = cd;
      cyc(40);
      seen = 0;
      set_src(ch, up, 1'b1);
      for (int k = 0; k < len; k++) begin
        cyc(1);
        seen |= ch ? brk_b : brk_a;
        check("R9 other channel quiet", ch ? brk_a : brk_b, 1'b0);
      end
      set_src(ch, up, 1'b0);
      for (int k = 0; k < d + 3; k++) begin
        cyc(1);
        seen |= ch ? brk_b : brk_a;
      end
      check($sformatf("R5 R4 vec%0d code%0d len%0d", v, cd, len), seen, ex);
      check($sformatf("R7 vec%0d cleared after drop", v), ch ? brk_b : brk_a, 1'b0);
    end

    // R2 bypass, combinational for comparator
    code_a = 4'd0; code_b = 4'd0;
    cyc(2);
    cmp_a = 1; #0.5;
    check("R2 bypass immediate", brk_a, 1'b1);
    check("R9 b untouched by a", brk_b, 1'b0);
    cmp_a = 0; #0.5;
    check("R2 bypass release", brk_a, 1'b0);
    @(negedge clk);

    // R8 pin through synchronizer in bypass: two edges
    pin_a = 1;
    cyc(1);
    check("R8 bypass pin after 1 edge", brk_a, 1'b0);
    cyc(1);
    check("R8 bypass pin after 2 edges", brk_a, 1'b1);
    pin_a = 0;
    cyc(3);

    // R3 active-low polarity
    pol_a = 0; cmp_a = 1; pin_a = 1;
    cyc(3);
    check("R3 low polarity idle", brk_a, 1'b0);
    cmp_a = 0; #0.5;
    check("R3 low polarity comparator asserts", brk_a, 1'b1);
    cmp_a = 1;
    @(negedge clk);
    pin_a = 0;
    cyc(2);
    check("R3 low polarity pin asserts", brk_a, 1'b1);
    pin_a = 1;
    cyc(3);
    pol_a = 1; cmp_a = 0; pin_a = 0;
    cyc(3);

    // R5 exact edge count, code 1 comparator
    code_a = 4'd1;
    cyc(3);
    cmp_a = 1;
    cyc(1);
    check("R5 code1 after 1 edge", brk_a, 1'b0);
    cyc(1);
    check("R5 code1 after 2 edges", brk_a, 1'b1);
    cmp_a = 0;
    cyc(1);
    check("R7 falls one edge after drop", brk_a, 1'b0);

    // R8 pin with code 1: four edges
    pin_a = 1;
    cyc(3);
    check("R8 code1 pin after 3 edges", brk_a, 1'b0);
    cyc(1);
    check("R8 code1 pin after 4 edges", brk_a, 1'b1);
    pin_a = 0;
    cyc(4);

    // R6 run count cleared by a gap (code 2, N=4)
    code_a = 4'd2;
    cyc(3);
    seen = 0;
    cmp_a = 1;
    for (int k = 0; k < 3; k++) begin cyc(1); seen |= brk_a; end
    cmp_a = 0;
    cyc(1); seen |= brk_a;
    cmp_a = 1;
    for (int k = 0; k < 3; k++) begin cyc(1); seen |= brk_a; end
    cmp_a = 0;
    cyc(2); seen |= brk_a;
    check("R6 split runs do not add", seen, 1'b0);

    // R9 channel B active while A filtered stays low
    code_b = 4'd0; cmp_b = 1;
    cyc(3);
    outv = brk_a;
    check("R9 a untouched by b", outv, 1'b0);
    check("R9 b active", brk_b, 1'b1);
    cmp_b = 0;
    cyc(2);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule